// File: doc/BRIEF.md
# Request-Grant Bus Handshake Monitor

This block is a passive observer for a simple request-grant bus. It never drives the bus. A master raises a one-cycle request. The arbiter answers with a grant in the next cycle. The master then issues either a read or a write. In the cycle after that command, the address-valid strobe must appear. So must the read-data-valid strobe (for a read) or the write-data-valid strobe (for a write). The monitor watches these seven control lines every clock. The address and data buses are not checked, and neither is memory content: only the timing relations between the control lines are.

Each rule class has its own error flag. A flag is set on the first violation of its rule and stays set until reset or until the clear input is raised. A combined flag shows whether any rule has been broken. A testbench or a system-level supervisor can watch these flags to catch a faulty master or arbiter. Some rules look back one cycle and one rule looks back two. Those rules are masked right after reset, until enough bus history has been seen, so the start-up cycles cannot raise false errors.

Top module: `hsk_monitor`

## Requirements
- R1: After a synchronous reset, every flag in `err_o` and `err_any_o` is 0. The flags stay 0 while the bus carries only legal transactions.
- R2: Bit 0 of `err_o` (sequence) sets when `rd_i` or `wr_i` is high in a cycle and it is not true that `req_i` was high two cycles earlier and `gnt_i` was high one cycle earlier.
- R3: Bit 1 (unrequested grant) sets when `gnt_i` is high in a cycle and `req_i` was low in the previous cycle.
- R4: Bit 2 (command clash) sets when `rd_i` and `wr_i` are high in the same cycle.
- R5: Bit 3 (address strobe) sets when `addr_vld_i` in a cycle differs from the OR of `rd_i` and `wr_i` in the previous cycle. This covers both a missing strobe and a spurious one.
- R6: Bit 4 (read data) sets when `din_vld_i` in a cycle differs from `rd_i` in the previous cycle.
- R7: Bit 5 (write data) sets when `dout_vld_i` in a cycle differs from `wr_i` in the previous cycle.
- R8: Bit 6 (request width) sets when `req_i` is high in two consecutive cycles.
- R9: A set flag holds until reset or until `clr_i` is sampled high. `clr_i` zeroes the flags at the next edge. A violation seen in the same cycle as `clr_i` is still recorded.
- R10: `err_any_o` equals the OR of all bits of `err_o`, and it is updated on the same edge.
- R11: In the first cycle after reset release, the rules that look back one cycle (R3, R5, R6, R7, R8) are masked. In the first two cycles, the rule that looks back two cycles (R2) is masked.
- R12: A violation in a cycle shows up on the outputs right after that cycle's rising clock edge: exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clears all sticky flags |
| req_i | input | 1 | Observed bus request |
| gnt_i | input | 1 | Observed bus grant |
| rd_i | input | 1 | Observed read command |
| wr_i | input | 1 | Observed write command |
| addr_vld_i | input | 1 | Observed address-valid strobe |
| din_vld_i | input | 1 | Observed read-data-valid strobe |
| dout_vld_i | input | 1 | Observed write-data-valid strobe |
| err_o | output | 7 | Sticky per-rule error flags (bit map in R2 to R8) |
| err_any_o | output | 1 | OR of all sticky flags |

## Verification
The only internal state is the one-cycle and two-cycle history of request, grant and command, the warm-up count, and the sticky flags. So any fault in that state shows at the flag outputs within one edge of the cycle that uses it. A stale history bit raises or hides a flag in the cycle after the command. A warm-up count that is off by one shows up as a false flag or a missing flag in the first or second cycle after reset. The bench models each rule from the requirements. It compares every flag and the combined flag after every edge, so a fault is reported in the very cycle it first shows.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  localparam int NRULE   = 7;
  localparam int R_SEQ   = 0;
  localparam int R_GNT   = 1;
  localparam int R_EXCL  = 2;
  localparam int R_ADDR  = 3;
  localparam int R_RDAT  = 4;
  localparam int R_WDAT  = 5;
  localparam int R_PULSE = 6;

  typedef struct packed {
    logic req;
    logic gnt;
    logic rd;
    logic wr;
    logic av;
    logic di;
    logic dout;
  } ctl_t;

  typedef struct packed {
    logic req;
    logic gnt;
    logic rd;
    logic wr;
  } hist_t;
endpackage

// File: rtl/hsk_history.sv
module hsk_history
  import hsk_pkg::*;
#(
  parameter int LOOKBACK = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  hist_t cur,
  output hist_t d1,
  output logic  req_d2,
  output logic  ok1,
  output logic  ok2
);
  localparam int CW = $clog2(LOOKBACK + 1);

  hist_t         d1_q;
  logic          req_d2_q;
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1_q     <= '0;
      req_d2_q <= 1'b0;
      seen_q   <= '0;
    end else begin
      d1_q     <= cur;
      req_d2_q <= d1_q.req;
      if (seen_q != CW'(LOOKBACK)) seen_q <= seen_q + 1'b1;
    end
  end

  assign d1     = d1_q;
  assign req_d2 = req_d2_q;
  assign ok1    = (seen_q >= CW'(1));
  assign ok2    = (seen_q >= CW'(2));
endmodule

// File: rtl/hsk_rules.sv
module hsk_rules
  import hsk_pkg::*;
(
  input  ctl_t             cur,
  input  hist_t            d1,
  input  logic             req_d2,
  input  logic             ok1,
  input  logic             ok2,
  output logic [NRULE-1:0] viol
);
  logic cmd_now, cmd_prev;

  always_comb begin
    cmd_now  = cur.rd | cur.wr;
    cmd_prev = d1.rd | d1.wr;
    viol          = '0;
    viol[R_SEQ]   = ok2 & cmd_now & ~(req_d2 & d1.gnt);
    viol[R_GNT]   = ok1 & cur.gnt & ~d1.req;
    viol[R_EXCL]  = cur.rd & cur.wr;
    viol[R_ADDR]  = ok1 & (cur.av ^ cmd_prev);
    viol[R_RDAT]  = ok1 & (cur.di ^ d1.rd);
    viol[R_WDAT]  = ok1 & (cur.dout ^ d1.wr);
    viol[R_PULSE] = ok1 & cur.req & d1.req;
  end
endmodule

// File: rtl/hsk_sticky.sv
module hsk_sticky #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] viol,
  output logic [N-1:0] err_q,
  output logic         any_q
);
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign nxt[i] = (err_q[i] & ~clr) | viol[i];
    always_ff @(posedge clk) begin
      if (rst) err_q[i] <= 1'b0;
      else     err_q[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |nxt;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && viol == '0) |=> (err_q == '0));
endmodule

// File: rtl/hsk_monitor.sv
module hsk_monitor
  import hsk_pkg::*;
#(
  parameter int LOOKBACK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             req_i,
  input  logic             gnt_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             addr_vld_i,
  input  logic             din_vld_i,
  input  logic             dout_vld_i,
  output logic [NRULE-1:0] err_o,
  output logic             err_any_o
);
  ctl_t             cur;
  hist_t            cur_h, d1;
  logic             req_d2, ok1, ok2;
  logic [NRULE-1:0] viol;

  assign cur   = '{req: req_i, gnt: gnt_i, rd: rd_i, wr: wr_i,
                   av: addr_vld_i, di: din_vld_i, dout: dout_vld_i};
  assign cur_h = '{req: req_i, gnt: gnt_i, rd: rd_i, wr: wr_i};

  hsk_history #(.LOOKBACK(LOOKBACK)) u_hist (
    .clk(clk), .rst(rst), .cur(cur_h), .d1(d1),
    .req_d2(req_d2), .ok1(ok1), .ok2(ok2)
  );

  hsk_rules u_rules (
    .cur(cur), .d1(d1), .req_d2(req_d2), .ok1(ok1), .ok2(ok2), .viol(viol)
  );

  hsk_sticky #(.N(NRULE)) u_sticky (
    .clk(clk), .rst(rst), .clr(clr_i), .viol(viol),
    .err_q(err_o), .any_q(err_any_o)
  );

  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_i && wr_i) |=> err_o[R_EXCL]);

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (req_i && ok1 && $past(req_i)) |=> err_o[R_PULSE]);

  p_any_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_any_o == (|err_o)));

  p_gnt_r3: assert property (@(posedge clk) disable iff (rst)
    (gnt_i && ok1 && !$past(req_i)) |=> err_o[R_GNT]);
endmodule

// File: tb/hsk_monitor_bench.sv
`timescale 1ns/1ps
module hsk_monitor_bench;
  import hsk_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic req = 1'b0, gnt = 1'b0, rd = 1'b0, wr = 1'b0;
  logic av = 1'b0, di = 1'b0, dov = 1'b0;
  logic [NRULE-1:0] err;
  logic             err_any;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [NRULE-1:0] expq[$];

  // bench-side rule model, written from the requirements
  logic [NRULE-1:0] m_err;
  logic m_req1, m_gnt1, m_rd1, m_wr1, m_req2;
  int   m_seen;

  always #2.5 clk = ~clk;

  hsk_monitor u_hsk_monitor (
    .clk(clk), .rst(rst), .clr_i(clr), .req_i(req), .gnt_i(gnt),
    .rd_i(rd), .wr_i(wr), .addr_vld_i(av), .din_vld_i(di),
    .dout_vld_i(dov), .err_o(err), .err_any_o(err_any)
  );

  function automatic string tag(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // monitor: compares each edge's outputs against the queued expectation (R12)
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      logic [NRULE-1:0] e;
      e = expq.pop_front();
      for (int i = 0; i < NRULE; i++) begin
        checks++;
        if (err[i] !== e[i]) begin
          failures++;
          $display("FAIL %s/R12 bit%0d actual=%b expected=%b t=%0t", tag(i), i, err[i], e[i], $time);
        end
      end
      checks++;
      if (err_any !== (|e)) begin
        failures++;
        $display("FAIL R10 err_any actual=%b expected=%b t=%0t", err_any, |e, $time);
      end
    end
  end

  task automatic step(input logic q, g, r, w, a, d, o, input logic c = 1'b0);
    logic [NRULE-1:0] v;
    req = q; gnt = g; rd = r; wr = w; av = a; di = d; dov = o; clr = c;
    v = '0;
    v[0] = (m_seen >= 2) && (r || w) && !(m_req2 && m_gnt1);
    v[1] = (m_seen >= 1) && g && !m_req1;
    v[2] = r && w;
    v[3] = (m_seen >= 1) && (a != (m_rd1 || m_wr1));
    v[4] = (m_seen >= 1) && (d != m_rd1);
    v[5] = (m_seen >= 1) && (o != m_wr1);
    v[6] = (m_seen >= 1) && q && m_req1;
    m_err = (c ? '0 : m_err) | v;
    expq.push_back(m_err);
    m_req2 = m_req1;
    m_req1 = q; m_gnt1 = g; m_rd1 = r; m_wr1 = w;
    if (m_seen < 2) m_seen++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0,0,0,0,0,0,0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req = 0; gnt = 0; rd = 0; wr = 0; av = 0; di = 0; dov = 0; clr = 0;
    repeat (2) @(negedge clk);
    checks++;
    if (err !== '0 || err_any !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset err=%b any=%b expected=0", err, err_any);
    end
    m_err = '0; m_req1 = 0; m_gnt1 = 0; m_rd1 = 0; m_wr1 = 0; m_req2 = 0; m_seen = 0;
    rst = 1'b0;
  endtask

  task automatic good_read();
    step(1,0,0,0,0,0,0); step(0,1,0,0,0,0,0);
    step(0,0,1,0,0,0,0); step(0,0,0,0,1,1,0);
  endtask

  task automatic good_write();
    step(1,0,0,0,0,0,0); step(0,1,0,0,0,0,0);
    step(0,0,0,1,0,0,0); step(0,0,0,0,1,0,1);
  endtask

  task automatic wipe();
    step(0,0,0,0,0,0,0,1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: legal traffic keeps all flags low
    idle(2); good_read(); good_write(); good_read(); idle(1);
    // R4: clashing read and write
    step(1,0,0,0,0,0,0); step(0,1,0,0,0,0,0);
    step(0,0,1,1,0,0,0); step(0,0,0,0,1,1,1);
    // R9: flag stays set while idle, then clear
    idle(3); wipe(); idle(1);
    // R2: command without request and grant
    step(0,0,1,0,0,0,0); step(0,0,0,0,1,1,0); wipe();
    // R3: grant without request
    step(0,1,0,0,0,0,0); wipe();
    // R8: two-cycle request (grant after it is legal)
    step(1,0,0,0,0,0,0); step(1,0,0,0,0,0,0); step(0,1,0,0,0,0,0);
    step(0,0,1,0,0,0,0); step(0,0,0,0,1,1,0); wipe();
    // R5: missing address strobe, then a spurious one
    step(1,0,0,0,0,0,0); step(0,1,0,0,0,0,0);
    step(0,0,1,0,0,0,0); step(0,0,0,0,0,1,0); wipe();
    step(0,0,0,0,1,0,0); wipe();
    // R6: spurious read-data strobe
    step(0,0,0,0,0,1,0); wipe();
    // R7: missing write-data strobe
    step(1,0,0,0,0,0,0); step(0,1,0,0,0,0,0);
    step(0,0,0,1,0,0,0); step(0,0,0,0,1,0,0); wipe();
    // R9: violation in the clear cycle is still recorded
    step(0,1,0,0,0,0,0,1); idle(1); wipe(); idle(1);
    // R11: look-back rules masked at start-up
    do_reset();
    step(0,1,0,0,1,1,0); step(0,0,1,0,0,0,0); step(0,0,0,0,1,1,0); idle(1);
    // R11: one-cycle rules active from the second cycle
    do_reset();
    step(0,0,0,0,0,0,0); step(0,1,0,0,0,0,0); idle(2);
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule